// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Interlock

This block holds the data-hazard decisions of a five-stage in-order integer pipeline. It looks at the register numbers of the instructions in decode and execute, and at the destination numbers and write flags of the three later stages. It does not touch any data. From these it produces two select codes, one for each ALU operand multiplexer. Each code says whether the operand comes from the register file, from the result held after execute, or from the result held after memory access.

The same block spots one case that bypassing cannot cover: a load in execute whose destination is a source of the instruction right behind it in decode. In that cycle it holds the program counter and the fetch/decode register. It also clears the control bits that go into the decode/execute register, so that a bubble enters execute. The dependent instruction and the one behind it each lose exactly one cycle.

The block is purely combinational. Its outputs follow its inputs within the same cycle and go straight to the pipeline registers and the operand multiplexers.

Top module: `hz_unit`

## Requirements
- R1: An operand select (`fwd_a` for `ex_rs1`, `fwd_b` for `ex_rs2`) is 2'b10 when `mem_wen` is 1, `mem_rd` is nonzero and `mem_rd` equals that operand's source number.
- R2: An operand select is 2'b01 when `wb_wen` is 1, `wb_rd` is nonzero and `wb_rd` equals that source number, as long as R1 does not apply to it.
- R3: When both later stages match the same source, the select is 2'b10, so the more recent result wins.
- R4: A destination number of 0 never causes forwarding, whatever the write flag says.
- R5: A stage whose write flag is 0 never causes forwarding, whatever its destination number is.
- R6: In every other case the select is 2'b00 (register-file value), and the code 2'b11 never appears.
- R7: When `ex_memrd` is 1, `ex_rd` is nonzero and `ex_rd` equals `id_rs1` or `id_rs2`, the block stalls in that same cycle: `pc_we`=0, `ifid_we`=0 and `idex_flush`=1.
- R8: Without the condition of R7, `pc_we`=1, `ifid_we`=1 and `idex_flush`=0. This covers a non-load in execute, a load into register 0, and a load whose destination matches neither decode source.
- R9: After one stall cycle the bubble reaches execute and the stall ends. The held instruction then enters execute with the loaded value bypassed from the memory/writeback register (select 2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| ex_rs1 | input | AW | First source register of the instruction in execute |
| ex_rs2 | input | AW | Second source register of the instruction in execute |
| ex_rd | input | AW | Destination register of the instruction in execute |
| ex_memrd | input | 1 | Instruction in execute reads data memory (load) |
| mem_rd | input | AW | Destination held in the execute/memory register |
| mem_wen | input | 1 | Register write flag held in the execute/memory register |
| wb_rd | input | AW | Destination held in the memory/writeback register |
| wb_wen | input | 1 | Register write flag held in the memory/writeback register |
| fwd_a | output | 2 | First ALU operand select: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b | output | 2 | Second ALU operand select, same encoding |
| pc_we | output | 1 | Program counter write enable (0 while stalling) |
| ifid_we | output | 1 | Fetch/decode register write enable (0 while stalling) |
| idex_flush | output | 1 | Clears the control bits entering decode/execute (1 while stalling) |

## Verification
The checks take for granted that the inputs are settled values, never X or Z, when they are sampled. They also treat each input combination on its own, with no history kept by the block. Random stimulus draws register numbers from a small range in most cycles, so that matches, register 0 and double matches come up often. It changes inputs only away from the sampling point, so every sample sees one complete, stable combination. A directed sequence walks a load and its consumer through the stall and bubble cycles, modelling the pipeline registers in the bench.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Operand source selects for the ALU input multiplexers
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hz_fwd_lane.sv
module hz_fwd_lane
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    sel
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  always_comb begin
    mem_hit = mem_wen && (mem_rd != ZERO_REG) && (mem_rd == src);
    wb_hit  = wb_wen  && (wb_rd  != ZERO_REG) && (wb_rd  == src);
  end

  // The newer result has priority
  always_comb begin
    if (mem_hit) begin
      sel = SEL_MEM;
    end else if (wb_hit) begin
      sel = SEL_WB;
    end else begin
      sel = SEL_RF;
    end
  end

endmodule

// File: rtl/hz_stall.sv
module hz_stall #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_memrd,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_flush
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic use_hit;
  logic stall;

  always_comb begin
    use_hit = (ex_rd == id_rs1) || (ex_rd == id_rs2);
    stall   = ex_memrd && (ex_rd != ZERO_REG) && use_hit;
  end

  always_comb begin
    pc_we      = !stall;
    ifid_we    = !stall;
    idex_flush = stall;
  end

endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_memrd,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_flush
);

  logic [AW-1:0] src_num [NUM_SRC];
  logic [1:0]    src_sel [NUM_SRC];

  always_comb begin
    src_num[0] = ex_rs1;
    src_num[1] = ex_rs2;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    hz_fwd_lane #(.AW(AW)) i_lane (
      .src     (src_num[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (src_sel[g])
    );
  end

  always_comb begin
    fwd_a = src_sel[0];
    fwd_b = src_sel[1];
  end

  hz_stall #(.AW(AW)) i_stall (
    .id_rs1     (id_rs1),
    .id_rs2     (id_rs2),
    .ex_rd      (ex_rd),
    .ex_memrd   (ex_memrd),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .idex_flush (idex_flush)
  );

endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic [AW-1:0] ex_rd,
  input logic          ex_memrd,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic [AW-1:0] wb_rd,
  input logic          wb_wen,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          idex_flush
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb begin
    // R1 / R3: a live newer producer always wins the operand
    if (mem_wen && mem_rd != ZERO_REG && mem_rd == ex_rs1) begin
      assert_fwd_a_mem_R1: assert (fwd_a == 2'b10);
    end
    if (mem_wen && mem_rd != ZERO_REG && mem_rd == ex_rs2) begin
      assert_fwd_b_mem_R3: assert (fwd_b == 2'b10);
    end
    // R5: no live writer at all means register-file data
    if (!mem_wen && !wb_wen) begin
      assert_no_writer_R5: assert (fwd_a == 2'b00 && fwd_b == 2'b00);
    end
    // R6: code 11 is never produced
    assert_sel_legal_R6: assert ($onehot0(fwd_a) && $onehot0(fwd_b));
    // R7: load-use match stalls every stage control together
    if (ex_memrd && ex_rd != ZERO_REG && (ex_rd == id_rs1 || ex_rd == id_rs2)) begin
      assert_load_use_R7: assert (!pc_we && !ifid_we && idex_flush);
    end
    // R8: without a load in execute nothing is held
    if (!ex_memrd) begin
      assert_no_stall_R8: assert (pc_we && ifid_we && !idex_flush);
    end
  end

endmodule

bind hz_unit hz_unit_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_hz_unit.sv
`timescale 1ns/1ps
module test_hz_unit;

  localparam int unsigned AW = 5;

  logic clk;
  logic rst_n;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_memrd, mem_wen, wb_wen;
  logic [1:0] fwd_a, fwd_b;
  logic pc_we, ifid_we, idex_flush;

  int checks;
  int errors;
  bit done;

  hz_unit #(.AW(AW)) i_hz_unit (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_memrd(ex_memrd), .mem_rd(mem_rd), .mem_wen(mem_wen),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_flush(idex_flush)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] s,
      input logic [AW-1:0] mr, input logic mw, input logic [AW-1:0] wr, input logic ww);
    if (mw && mr != 0 && mr == s) return 2'b10;
    if (ww && wr != 0 && wr == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_stall(input logic [AW-1:0] a, input logic [AW-1:0] b,
      input logic [AW-1:0] rd, input logic ld);
    return ld && rd != 0 && (rd == a || rd == b);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] i1, input logic [AW-1:0] i2,
      input logic [AW-1:0] e1, input logic [AW-1:0] e2, input logic [AW-1:0] erd,
      input logic eld, input logic [AW-1:0] mr, input logic mw,
      input logic [AW-1:0] wr, input logic ww);
    @(negedge clk);
    id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2; ex_rd = erd;
    ex_memrd = eld; mem_rd = mr; mem_wen = mw; wb_rd = wr; wb_wen = ww;
    #1;
  endtask

  task automatic check_all(input string tag);
    logic st;
    st = exp_stall(id_rs1, id_rs2, ex_rd, ex_memrd);
    check({tag, " fwd_a"}, {6'd0, fwd_a}, {6'd0, exp_sel(ex_rs1, mem_rd, mem_wen, wb_rd, wb_wen)});
    check({tag, " fwd_b"}, {6'd0, fwd_b}, {6'd0, exp_sel(ex_rs2, mem_rd, mem_wen, wb_rd, wb_wen)});
    check({tag, " stall"}, {5'd0, pc_we, ifid_we, idex_flush}, {5'd0, !st, !st, st});
  endtask

  function automatic logic [AW-1:0] pick();
    if ($urandom_range(0, 3) != 0) return AW'($urandom_range(0, 3));
    return AW'($urandom);
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    checks = 0; errors = 0; done = 0;
    seed = $urandom(32'd2024);
    rst_n = 1'b0;
    id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0;
    ex_memrd = 1'b0; mem_rd = '0; mem_wen = 1'b0; wb_rd = '0; wb_wen = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // idle state: all inputs zero
    check("R6 idle fwd", {4'd0, fwd_a, fwd_b}, 8'h00);
    check("R8 idle stall", {5'd0, pc_we, ifid_we, idex_flush}, 8'h06);

    // directed corners
    drive(0, 0, 5, 6, 0, 0, 5, 1, 0, 0);
    check("R1 mem to a", {6'd0, fwd_a}, 8'h02);
    drive(0, 0, 5, 6, 0, 0, 6, 1, 0, 0);
    check("R1 mem to b", {6'd0, fwd_b}, 8'h02);
    drive(0, 0, 7, 7, 0, 0, 0, 0, 7, 1);
    check("R2 wb to a,b", {4'd0, fwd_a, fwd_b}, 8'h05);
    drive(0, 0, 9, 3, 0, 0, 9, 1, 9, 1);
    check("R3 priority", {4'd0, fwd_a, fwd_b}, 8'h08);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    check("R4 x0", {4'd0, fwd_a, fwd_b}, 8'h00);
    drive(0, 0, 4, 4, 0, 0, 4, 0, 4, 0);
    check("R5 wen low", {4'd0, fwd_a, fwd_b}, 8'h00);
    drive(0, 0, 4, 8, 0, 0, 4, 0, 8, 0);
    check("R6 no match", {4'd0, fwd_a, fwd_b}, 8'h00);
    drive(3, 1, 0, 0, 3, 1, 0, 0, 0, 0);
    check("R7 load-use rs1", {5'd0, pc_we, ifid_we, idex_flush}, 8'h01);
    drive(1, 3, 0, 0, 3, 1, 0, 0, 0, 0);
    check("R7 load-use rs2", {5'd0, pc_we, ifid_we, idex_flush}, 8'h01);
    drive(3, 3, 0, 0, 3, 0, 0, 0, 0, 0);
    check("R8 non-load", {5'd0, pc_we, ifid_we, idex_flush}, 8'h06);
    drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    check("R8 load to x0", {5'd0, pc_we, ifid_we, idex_flush}, 8'h06);
    drive(1, 2, 0, 0, 3, 1, 0, 0, 0, 0);
    check("R8 load no match", {5'd0, pc_we, ifid_we, idex_flush}, 8'h06);

    // R9: load x10 in EX, consumer (x10, x11) in ID
    drive(10, 11, 1, 2, 10, 1, 0, 0, 0, 0);
    check("R9 stall cycle", {5'd0, pc_we, ifid_we, idex_flush}, 8'h01);
    // bubble in EX, load in MEM, consumer still in ID
    drive(10, 11, 0, 0, 0, 0, 10, 1, 0, 0);
    check("R9 bubble cycle", {5'd0, pc_we, ifid_we, idex_flush}, 8'h06);
    // consumer in EX, bubble in MEM, load in WB
    drive(0, 0, 10, 11, 12, 0, 0, 0, 10, 1);
    check("R9 consumer bypass", {4'd0, fwd_a, fwd_b}, 8'h04);

    // random stimulus
    for (int n = 0; n < 3000; n++) begin
      drive(pick(), pick(), pick(), pick(), pick(), 1'($urandom),
            pick(), 1'($urandom), pick(), 1'($urandom));
      check_all("R1-R8 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule